// File: doc/BRIEF.md
# Texture Packet Buffer and Parser

This block gathers 32-bit words written to a texture port into a local buffer. On a command-port flush it walks the buffer as a chain of texture packets. Each packet's first word gives its length, the second word is the texture header, and the words after that are texel data. The header and data words of each packet go to a downstream texture writer one at a time, under a valid/ready handshake. The header is marked as the first word of the packet and the final forwarded word is marked as the last. When the walk ends, a one-cycle done pulse is raised and the buffer is emptied.

If a write arrives while the buffer is full, the write is lost and a sticky error flag is raised. A pulse marking the end of vertical blank clears that flag, so it is cleared once per frame. A second input mode bypasses the buffer. In that mode, port writes are taken in groups of three. The first word is an external source address and the second is a header. The third word starts an upload that uses those two values, and it also tells the consumer which of two memories to fetch from, chosen by comparing the address with a split point.

Top module: `tex_packet_fifo`

## Requirements
- R1: After reset, outValid, flushDone, errFlag and altLaunch are all 0.
- R2: With altMode low and no flush in progress, each port write is stored at the next buffer position, up to BUF_DEPTH words. Nothing is forwarded before a flush.
- R3: With altMode low, a write to a full buffer is dropped and sets errFlag. errFlag stays set through later flushes and writes until it is cleared.
- R4: A vblankEnd pulse clears errFlag on the next edge. If an overflowing write arrives in the same cycle, errFlag is set instead.
- R5: A flush when the buffer holds 0, 1 or 2 words forwards nothing and still pulses flushDone.
- R6: A packet starting at index b has length L = (2 + floor(w/2)) / 4, computed unsigned on 32 bits from w = word b. The block forwards word b+1 with outFirst=1, then words b+2 up to b+L-1. If L is 1, only the header is forwarded. Words at or beyond the buffered count are never forwarded. outLast marks the final forwarded word.
- R7: A packet whose computed length is 0 ends the walk, and the rest of the buffer is discarded.
- R8: The next packet starts at b+L. The walk continues only while that start index is below the buffered count minus 2.
- R9: Every flush ends with flushDone high for exactly one cycle. Afterwards the buffer is empty, so a following flush with no writes forwards nothing.
- R10: While outValid is high and outReady is low, outValid stays high and outData and outFirst hold their values.
- R11: With altMode high, the 1st port write is taken as an address and the 2nd as a header. The 3rd write is discarded and causes altLaunch to pulse for one cycle on the next cycle, carrying that address and header. After that the capture restarts. Writes in this mode never enter the buffer.
- R12: altUseSecond is 1 when the captured address is below ALT_SPLIT (default 0x100000), and 0 otherwise.
- R13: From the cycle a flush is accepted through its flushDone cycle, buffer writes and further flush requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWrValid | input | 1 | Texture port write strobe |
| portWrData | input | 32 | Texture port write data |
| altMode | input | 1 | Selects the three-write address/header launch mode |
| flushReq | input | 1 | Command-port flush request |
| vblankEnd | input | 1 | End-of-vertical-blank pulse, clears errFlag |
| outValid | output | 1 | Forwarded word valid |
| outReady | input | 1 | Downstream writer accepts the word |
| outData | output | 32 | Forwarded header or data word |
| outFirst | output | 1 | Forwarded word is a packet header |
| outLast | output | 1 | Forwarded word is the final word of its packet |
| flushDone | output | 1 | One-cycle pulse when a flush completes |
| errFlag | output | 1 | Sticky buffer overflow flag |
| altLaunch | output | 1 | One-cycle upload launch pulse in alternate mode |
| altAddr | output | 32 | Captured source address |
| altHdr | output | 32 | Captured texture header |
| altUseSecond | output | 1 | Fetch from the second memory (address below split) |

## Verification
The hardest cases to reach from the ports are an overflowing write that lands in the same cycle as the frame clear, and a buffer whose last packet claims more words than were written. The bench reaches these with a small buffer. It sweeps every fill level from empty to full, plus one word past full. The sweep uses generated packet chains, and some chains carry a zero-length word or a huge length word. Backpressure patterns stall the output mid-packet. A flush is also hit with a write and a second flush while it is still walking.

// File: rtl/tex_packet_fifo_pkg.sv
package tex_packet_fifo_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN_RD, ST_LEN_EV, ST_WORD_RD, ST_WORD_OUT, ST_DONE
  } parse_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptWr;
    logic startParse;
    logic loadPkt;
    logic advWord;
    logic nextPkt;
    logic clearIdx;
    logic readCur;
  } dp_ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic fewWords;
    logic lenZero;
    logic lastWord;
    logic morePkts;
  } dp_stat_t;

  // packet length in words from the leading word
  function automatic word_t pktLength(word_t w);
    return ((w >> 1) + word_t'(2)) >> 2;
  endfunction
endpackage

// File: rtl/tex_packet_fifo_dp.sv
module tex_packet_fifo_dp
  import tex_packet_fifo_pkg::*;
#(
  parameter int          BUF_DEPTH = 256,
  parameter logic [31:0] ALT_SPLIT = 32'h0010_0000
) (
  input  logic     clk,
  input  logic     rstN,
  input  dp_ctrl_t ctl,
  output dp_stat_t stat,
  input  logic     portWrValid,
  input  word_t    portWrData,
  input  logic     altMode,
  input  logic     vblankEnd,
  output word_t    rdWord,
  output logic     isHeader,
  output logic     errFlag,
  output logic     altLaunch,
  output word_t    altAddr,
  output word_t    altHdr,
  output logic     altUseSecond
);
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  word_t             mem [BUF_DEPTH];
  logic [CNT_W-1:0]  wrCnt;
  word_t             count32;
  word_t             base, cur, pktEnd;
  logic              bufFull, bufWr;
  logic [IDX_W-1:0]  rdIdx;
  logic [1:0]        altIdx;

  assign count32 = word_t'(wrCnt);
  assign bufFull = (wrCnt == CNT_W'(BUF_DEPTH));
  assign bufWr   = ctl.acceptWr && portWrValid && !altMode;
  assign rdIdx   = ctl.readCur ? cur[IDX_W-1:0] : base[IDX_W-1:0];

  // buffer storage, synchronous read
  always_ff @(posedge clk) begin
    if (bufWr && !bufFull) mem[wrCnt[IDX_W-1:0]] <= portWrData;
    rdWord <= mem[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.clearIdx)            wrCnt <= '0;
      else if (bufWr && !bufFull)  wrCnt <= wrCnt + 1'b1;
      if (bufWr && bufFull)        errFlag <= 1'b1;
      else if (vblankEnd)          errFlag <= 1'b0;
    end
  end

  // packet walk indices
  always_ff @(posedge clk) begin
    if (!rstN) begin
      base   <= '0;
      cur    <= '0;
      pktEnd <= '0;
    end else begin
      if (ctl.startParse) base <= '0;
      if (ctl.nextPkt)    base <= pktEnd;
      if (ctl.loadPkt) begin
        cur    <= base + word_t'(1);
        pktEnd <= base + pktLength(rdWord);
      end
      if (ctl.advWord)    cur <= cur + word_t'(1);
    end
  end

  assign stat.fewWords = (count32 <= word_t'(2));
  assign stat.lenZero  = (pktLength(rdWord) == '0);
  assign stat.lastWord = (cur + word_t'(1) >= pktEnd) || (cur + word_t'(1) >= count32);
  assign stat.morePkts = (pktEnd + word_t'(2) < count32);
  assign isHeader      = (cur == base + word_t'(1));

  // alternate three-write capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      altIdx    <= '0;
      altAddr   <= '0;
      altHdr    <= '0;
      altLaunch <= 1'b0;
    end else begin
      altLaunch <= 1'b0;
      if (portWrValid && altMode) begin
        case (altIdx)
          2'd0:    begin altAddr <= portWrData; altIdx <= 2'd1; end
          2'd1:    begin altHdr  <= portWrData; altIdx <= 2'd2; end
          default: begin altLaunch <= 1'b1;     altIdx <= 2'd0; end
        endcase
      end
    end
  end

  assign altUseSecond = (altAddr < ALT_SPLIT);
endmodule

// File: rtl/tex_packet_fifo_ctrl.sv
module tex_packet_fifo_ctrl
  import tex_packet_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flushReq,
  input  logic     outReady,
  input  dp_stat_t stat,
  output dp_ctrl_t ctl,
  output logic     outValid,
  output logic     flushDone
);
  parse_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    outValid  = 1'b0;
    flushDone = 1'b0;
    case (state)
      ST_IDLE: begin
        ctl.acceptWr = !flushReq;
        if (flushReq) begin
          if (stat.fewWords) nextState = ST_DONE;
          else begin
            ctl.startParse = 1'b1;
            nextState      = ST_LEN_RD;
          end
        end
      end
      ST_LEN_RD: nextState = ST_LEN_EV;
      ST_LEN_EV: begin
        if (stat.lenZero) nextState = ST_DONE;
        else begin
          ctl.loadPkt = 1'b1;
          nextState   = ST_WORD_RD;
        end
      end
      ST_WORD_RD: begin
        ctl.readCur = 1'b1;
        nextState   = ST_WORD_OUT;
      end
      ST_WORD_OUT: begin
        ctl.readCur = 1'b1;
        outValid    = 1'b1;
        if (outReady) begin
          if (stat.lastWord) begin
            ctl.nextPkt = 1'b1;
            nextState   = stat.morePkts ? ST_LEN_RD : ST_DONE;
          end else begin
            ctl.advWord = 1'b1;
            nextState   = ST_WORD_RD;
          end
        end
      end
      ST_DONE: begin
        ctl.clearIdx = 1'b1;
        flushDone    = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/tex_packet_fifo.sv
module tex_packet_fifo
  import tex_packet_fifo_pkg::*;
#(
  parameter int          BUF_DEPTH = 256,
  parameter logic [31:0] ALT_SPLIT = 32'h0010_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portWrValid,
  input  logic [31:0] portWrData,
  input  logic        altMode,
  input  logic        flushReq,
  input  logic        vblankEnd,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        outFirst,
  output logic        outLast,
  output logic        flushDone,
  output logic        errFlag,
  output logic        altLaunch,
  output logic [31:0] altAddr,
  output logic [31:0] altHdr,
  output logic        altUseSecond
);
  dp_ctrl_t ctl;
  dp_stat_t stat;
  logic     isHeader;

  tex_packet_fifo_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .outReady(outReady),
    .stat(stat), .ctl(ctl), .outValid(outValid), .flushDone(flushDone)
  );

  tex_packet_fifo_dp #(.BUF_DEPTH(BUF_DEPTH), .ALT_SPLIT(ALT_SPLIT)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .portWrValid(portWrValid), .portWrData(portWrData), .altMode(altMode),
    .vblankEnd(vblankEnd), .rdWord(outData), .isHeader(isHeader),
    .errFlag(errFlag), .altLaunch(altLaunch), .altAddr(altAddr),
    .altHdr(altHdr), .altUseSecond(altUseSecond)
  );

  assign outFirst = outValid && isHeader;
  assign outLast  = outValid && stat.lastWord;
endmodule

// File: rtl/tex_packet_fifo_chk.sv
module tex_packet_fifo_chk (
  input logic        clk,
  input logic        rstN,
  input logic        portWrValid,
  input logic        vblankEnd,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outFirst,
  input logic        flushDone,
  input logic        errFlag,
  input logic        altLaunch
);
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFirst));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  a_r13_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> !outValid);

  a_r11_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    altLaunch |=> !altLaunch);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !vblankEnd |=> errFlag);

  a_r4_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    vblankEnd && !portWrValid |=> !errFlag);
endmodule

bind tex_packet_fifo tex_packet_fifo_chk chk_i (
  .clk(clk), .rstN(rstN), .portWrValid(portWrValid), .vblankEnd(vblankEnd),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outFirst(outFirst), .flushDone(flushDone), .errFlag(errFlag),
  .altLaunch(altLaunch)
);

// File: tb/tex_packet_fifo_tb_top.sv
module tex_packet_fifo_tb_top;
  localparam int          DEPTH = 16;
  localparam logic [31:0] SPLIT = 32'h0010_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0, portWrValid = 1'b0, altMode = 1'b0;
  logic        flushReq = 1'b0, vblankEnd = 1'b0, outReady = 1'b0;
  logic [31:0] portWrData = '0;
  logic        outValid, outFirst, outLast, flushDone, errFlag;
  logic        altLaunch, altUseSecond;
  logic [31:0] outData, altAddr, altHdr;

  tex_packet_fifo #(.BUF_DEPTH(DEPTH), .ALT_SPLIT(SPLIT)) dut_i (
    .clk(clk), .rstN(rstN), .portWrValid(portWrValid), .portWrData(portWrData),
    .altMode(altMode), .flushReq(flushReq), .vblankEnd(vblankEnd),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFirst(outFirst), .outLast(outLast), .flushDone(flushDone),
    .errFlag(errFlag), .altLaunch(altLaunch), .altAddr(altAddr),
    .altHdr(altHdr), .altUseSecond(altUseSecond)
  );

  int checks = 0, errors = 0;
  logic [31:0] mw [DEPTH+1];
  int mn = 0;
  logic [31:0] capD [64];
  bit capF [64], capL [64];
  int capN = 0, doneCnt = 0, cyc = 0, readyMode = 0, holdErr = 0;
  bit stallPrev = 0;
  logic [31:0] stallData = '0;

  // monitor and backpressure, all at the falling edge
  always @(negedge clk) begin
    bit r;
    cyc++;
    case (readyMode)
      0:       r = 1'b1;
      1:       r = (cyc % 3) != 0;
      default: r = (cyc % 2) == 1;
    endcase
    if (stallPrev && (!outValid || outData != stallData)) holdErr++;
    outReady = r;
    if (outValid && r && capN < 64) begin
      capD[capN] = outData; capF[capN] = outFirst; capL[capN] = outLast; capN++;
    end
    stallPrev = outValid && !r;
    stallData = outData;
    if (flushDone) doneCnt++;
  end

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    int p = 0, k = 0;
    while (p < DEPTH + 1) begin
      longint len;
      logic [31:0] w0;
      if (seed == 2 && k == 2)      begin w0 = 32'd3;          len = 1; end
      else if (seed == 1 && k == 1) begin w0 = 32'hFFFF_FFF8;  len = 64; end
      else begin
        len = (seed + k) % 4 + 1;
        w0  = 32'(8 * len - 4 + (k % 4));
      end
      mw[p] = w0;
      for (int j = 1; j < len && p + j < DEPTH + 1; j++)
        mw[p+j] = 32'h5A00_0000 ^ {8'(seed), 8'(k), 16'(j)};
      p += int'(len);
      k++;
    end
  endtask

  task automatic push(input logic [31:0] d);
    portWrValid = 1'b1; portWrData = d;
    @(negedge clk);
    portWrValid = 1'b0;
  endtask

  task automatic doFlush(input bit inject);
    int d0 = doneCnt, t = 0;
    capN = 0;
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    if (inject) begin
      @(negedge clk);
      portWrValid = 1'b1; portWrData = 32'hDEAD_0001; flushReq = 1'b1;
      @(negedge clk);
      portWrValid = 1'b0; flushReq = 1'b0;
    end
    while (doneCnt == d0 && t < 3000) begin @(negedge clk); t++; end
    check("R9 flush completes", t < 3000, t, 0);
  endtask

  // expected stream from the requirements, compared against capture
  task automatic checkStream(input string req);
    logic [31:0] eD [64];
    bit eF [64], eL [64];
    int eN = 0, n;
    bit bad = 0;
    n = (mn > DEPTH) ? DEPTH : mn;
    if (n > 2) begin
      longint i = 0;
      while (i < n - 2) begin
        longint sz = (longint'(mw[i]) / 2 + 2) / 4;
        if (sz == 0) break;
        eD[eN] = mw[i+1]; eF[eN] = 1; eL[eN] = 0; eN++;
        for (longint j = i + 2; j < i + sz && j < n; j++) begin
          eD[eN] = mw[j]; eF[eN] = 0; eL[eN] = 0; eN++;
        end
        eL[eN-1] = 1;
        i += sz;
      end
    end
    if (capN != eN) bad = 1;
    else for (int q = 0; q < eN; q++)
      if (capD[q] != eD[q] || capF[q] != eF[q] || capL[q] != eL[q]) bad = 1;
    check(req, !bad, capN, eN);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset outputs", !outValid && !flushDone && !errFlag && !altLaunch,
          {outValid, flushDone, errFlag, altLaunch}, 0);

    // R2 R5 R6 R7 R8: every fill level, three chain shapes and backpressure patterns
    for (int seed = 0; seed < 3; seed++) begin
      readyMode = seed;
      fill(seed);
      for (int n = 0; n <= DEPTH; n++) begin
        mn = n;
        for (int q = 0; q < n; q++) push(mw[q]);
        doFlush(0);
        if (n <= 2) checkStream("R5 short buffer");
        else        checkStream("R2 R6 R7 R8 packet stream");
      end
    end
    check("R10 stalled word held", holdErr == 0, holdErr, 0);

    // R9: buffer empty after a flush
    readyMode = 0;
    fill(0); mn = 10;
    for (int q = 0; q < 10; q++) push(mw[q]);
    doFlush(0);
    checkStream("R9 first flush");
    mn = 0; doFlush(0);
    checkStream("R9 empty after flush");

    // R13: write and flush request during a walk are ignored
    readyMode = 1;
    fill(1); mn = 12;
    for (int q = 0; q < 12; q++) push(mw[q]);
    begin
      int d0;
      d0 = doneCnt;
      doFlush(1);
      checkStream("R13 stream unaffected");
      repeat (5) @(negedge clk);
      check("R13 extra flush ignored", doneCnt == d0 + 1, doneCnt - d0, 1);
    end
    mn = 0; doFlush(0);
    checkStream("R13 write during walk dropped");

    // R3: overflow
    readyMode = 0;
    fill(0); mn = DEPTH + 1;
    for (int q = 0; q < DEPTH; q++) push(mw[q]);
    check("R3 no error when exactly full", errFlag == 0, errFlag, 0);
    push(mw[DEPTH]);
    check("R3 overflow sets error", errFlag == 1, errFlag, 1);
    doFlush(0);
    checkStream("R3 overflow word dropped");
    check("R3 error sticky over flush", errFlag == 1, errFlag, 1);

    // R4: clear, and overflow wins over clear
    vblankEnd = 1'b1; @(negedge clk); vblankEnd = 1'b0;
    check("R4 clear", errFlag == 0, errFlag, 0);
    fill(2); mn = DEPTH;
    for (int q = 0; q < DEPTH; q++) push(mw[q]);
    portWrValid = 1'b1; portWrData = 32'h0BAD_0BAD; vblankEnd = 1'b1;
    @(negedge clk);
    portWrValid = 1'b0; vblankEnd = 1'b0;
    check("R4 overflow beats clear", errFlag == 1, errFlag, 1);
    vblankEnd = 1'b1; @(negedge clk); vblankEnd = 1'b0;
    check("R4 clear later", errFlag == 0, errFlag, 0);
    doFlush(0);
    checkStream("R4 buffer intact");

    // R11 R12: alternate mode
    altMode = 1'b1;
    push(32'h000F_FFFF);
    push(32'hCAFE_1234);
    check("R11 no early launch", altLaunch == 0, altLaunch, 0);
    push(32'h7777_7777);
    check("R11 launch pulse", altLaunch == 1 && altAddr == 32'h000F_FFFF && altHdr == 32'hCAFE_1234,
          altAddr, 32'h000F_FFFF);
    check("R12 below split uses second", altUseSecond == 1, altUseSecond, 1);
    @(negedge clk);
    check("R11 launch one cycle", altLaunch == 0, altLaunch, 0);
    push(32'h0010_0000);
    push(32'h0000_0055);
    push(32'h1);
    check("R11 second launch", altLaunch == 1 && altHdr == 32'h0000_0055, altHdr, 32'h55);
    check("R12 at split uses external", altUseSecond == 0, altUseSecond, 0);
    altMode = 1'b0;
    mn = 0; doFlush(0);
    checkStream("R11 writes not buffered");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule